// File: doc/BRIEF.md
# Quad Double-Buffered DAC Register Controller

This block keeps the digital state of a four-channel DAC. Every channel has a 16-bit staging (input) register and a 16-bit live (DAC) register. Complete 32-bit frames arrive from a serial receiver as a one-cycle `frame_valid` pulse. The block decodes each frame and applies it: it stages codes, promotes them to the live registers, programs the power-down state of each output stage, sets the clear code and the per-channel load-override mask, or resets the whole block.

The block also has three hardware inputs:
- An active-low load strobe promotes staged codes on every channel that is not overridden.
- An active-low clear input, acting on its falling edge, forces every register to a programmable code.
- A tie-off pin selects whether reset gives zero scale or midscale.

The outputs are the four live codes and a 2-bit output-stage mode for each channel. A converter stage uses these outputs.

Every effect takes place on the rising clock edge at which its cause is sampled. The result is visible on the outputs right after that edge.

Top module: `quad_dac_regs`

## Requirements
- R1: While `rst_n` is low, and after it rises, every input and DAC register holds 0x0000 if `por_mid`=0 or 0x8000 if `por_mid`=1. All modes are 00, the override mask is 0000 and the clear-code select is 00.
- R2: A frame carries the command in bits 27:24, the address in bits 23:20 and a 16-bit value in bits 19:4. Address 0000/0001/0010/0011 selects channel A/B/C/D and 1111 selects all four. Any other address selects no channel.
- R3: Command 0000 writes the value to the input register of each addressed channel. The DAC register of that channel is unchanged while `load_n` is high and its override bit is 0.
- R4: Command 0001 copies the input register of each addressed channel into its DAC register.
- R5: Command 0010 writes the value to the addressed input registers, then copies all four input registers, including the new values, into the DAC registers.
- R6: Command 0011 writes the value to both the input and the DAC register of each addressed channel.
- R7: Command 0110 loads the override mask from bits 3:0, with bit 0 for A through bit 3 for D. A channel whose bit is 1 updates its DAC register on the same edge as any write to its input register, whatever the state of `load_n`.
- R8: On every edge with `load_n` low and `clear_n` high, each channel whose override bit is 0 copies its input register, including a value written on that edge, into its DAC register.
- R9: Command 0101 sets the clear select from bits 1:0. A falling edge of `clear_n` then loads every input and DAC register with 0x0000 (select 00), 0x8000 (select 01) or 0xFFFF (select 10). Select 11 changes nothing. On the same edge the clear takes priority over a frame, and that frame is dropped.
- R10: While `clear_n` is held low, `load_n` has no effect.
- R11: Command 0100 writes bits 9:8 as the mode (00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 open) to each channel selected by bits 3:0, with bit 0 for A. The address field is ignored. DAC registers keep their contents. `out_mode` carries channel A in bits 1:0 up to channel D in bits 7:6.
- R12: When a channel goes from a non-zero mode to 00 while `load_n` is low, its DAC register takes its input register. If `load_n` is high, the DAC register keeps its value.
- R13: Command 0111 restores the R1 state using the current `por_mid`. A clear edge or a low `load_n` on the same edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle pulse: `frame_data` holds a complete frame |
| frame_data | input | 32 | Received frame |
| load_n | input | 1 | Active-low hardware load strobe (synchronous to `clk`) |
| clear_n | input | 1 | Active-low clear, acts on its falling edge (synchronous to `clk`) |
| por_mid | input | 1 | Reset code select: 0 zero scale, 1 midscale |
| dac_code | output | 64 | Live codes, channel A in bits 15:0 up to D in bits 63:48 |
| out_mode | output | 8 | Output-stage mode, two bits per channel, A lowest |

## Verification
The staging path is driven with:
- Single-channel writes, to show that only the staging register changes.
- A promote command, to show that the copy is per channel.
- A write-and-promote-all, to show that it captures a value written on the same edge.
- A broadcast write-and-promote.
- A write to an unused address with the load strobe low, to show that the address is dropped rather than aliased.

Writes with the load strobe low, and on an overridden channel, separate the immediate-update paths from the held ones.

The clear is tried with each of its four selects and combined with a load pulse. The power-up restore is tried with the strobe high and low. A software reset is issued together with a clear edge, to show the priority between them.

// File: rtl/quad_dac_regs.sv
module quad_dac_regs #(
  parameter int W  = 16,
  parameter int CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_valid,
  input  logic [31:0]     frame_data,
  input  logic            load_n,
  input  logic            clear_n,
  input  logic            por_mid,
  output logic [CH*W-1:0] dac_code,
  output logic [CH*2-1:0] out_mode
);
  localparam logic [W-1:0] MID  = W'(1) << (W-1);
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] inp [CH];
  logic [W-1:0] dac [CH];
  logic [W-1:0] inp_nx [CH];
  logic [1:0]   mode [CH];
  logic [CH-1:0] ovr;
  logic [1:0]   csel;
  logic         clr_q;
  logic [CH-1:0] sel;
  logic [W-1:0] clr_code;

  wire [3:0]   cmd  = frame_data[27:24];
  wire [3:0]   adr  = frame_data[23:20];
  wire [W-1:0] val  = frame_data[19:4];
  wire [1:0]   pdm  = frame_data[9:8];
  wire [CH-1:0] msk = frame_data[CH-1:0];

  wire clr_fall = clr_q & ~clear_n;
  wire sw_rst   = frame_valid && cmd == 4'h7;
  wire do_wr    = frame_valid && (cmd == 4'h0 || cmd == 4'h2 || cmd == 4'h3);
  wire pin_ld   = !load_n && clear_n;
  wire [W-1:0] por_code = por_mid ? MID : '0;

  always_comb begin
    if (adr == 4'hF)        sel = '1;
    else if (adr[3:2] == 0) sel = CH'(1) << adr[1:0];
    else                    sel = '0;
  end

  always_comb begin
    case (csel)
      2'b00:   clr_code = '0;
      2'b01:   clr_code = MID;
      default: clr_code = FULL;
    endcase
  end

  always_comb
    for (int i = 0; i < CH; i++)
      inp_nx[i] = (do_wr && sel[i]) ? val : inp[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clr_q <= 1'b1;
    else        clr_q <= clear_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr  <= '0;
      csel <= 2'b00;
      for (int i = 0; i < CH; i++) begin
        inp[i]  <= por_code;
        dac[i]  <= por_code;
        mode[i] <= 2'b00;
      end
    end else if (sw_rst) begin
      ovr  <= '0;
      csel <= 2'b00;
      for (int i = 0; i < CH; i++) begin
        inp[i]  <= por_code;
        dac[i]  <= por_code;
        mode[i] <= 2'b00;
      end
    end else if (clr_fall) begin
      if (csel != 2'b11)
        for (int i = 0; i < CH; i++) begin
          inp[i] <= clr_code;
          dac[i] <= clr_code;
        end
    end else begin
      if (frame_valid && cmd == 4'h5) csel <= frame_data[1:0];
      if (frame_valid && cmd == 4'h6) ovr  <= msk;
      for (int i = 0; i < CH; i++) begin
        inp[i] <= inp_nx[i];
        if ((frame_valid && cmd == 4'h2) ||
            (frame_valid && cmd == 4'h1 && sel[i]) ||
            (do_wr && sel[i] && (cmd == 4'h3 || ovr[i])) ||
            (pin_ld && !ovr[i]))
          dac[i] <= inp_nx[i];
        if (frame_valid && cmd == 4'h4 && msk[i]) begin
          mode[i] <= pdm;
          if (pdm == 2'b00 && mode[i] != 2'b00 && !load_n)
            dac[i] <= inp[i];
        end
      end
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_out
    assign dac_code[g*W +: W] = dac[g];
    assign out_mode[g*2 +: 2] = mode[g];
  end

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !frame_valid && !clr_fall) |=> $stable(dac_code));

  // R10
  clear_low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_n && !clr_q && !frame_valid) |=> $stable(dac_code));

  // R9
  clear_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fall && !sw_rst && csel == 2'b01) |=> dac_code == {CH{MID}});

  // R13
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (out_mode == '0 &&
               dac_code == {CH{($past(por_mid) ? MID : W'(0))}}));

  // R11
  pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && cmd == 4'h4 && pdm != 2'b00 && load_n && !clr_fall)
      |=> $stable(dac_code));

  // R7
  override_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && cmd == 4'h0 && adr == 4'h0 && ovr[0] && !clr_fall)
      |=> dac_code[W-1:0] == $past(val));
endmodule

// File: tb/quad_dac_regs_tb_top.sv
module quad_dac_regs_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        frame_valid = 0;
  logic [31:0] frame_data = '0;
  logic        load_n = 1;
  logic        clear_n = 1;
  logic        por_mid = 0;
  logic [63:0] dac_code;
  logic [7:0]  out_mode;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_dac_regs dut_i (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .load_n(load_n), .clear_n(clear_n), .por_mid(por_mid),
    .dac_code(dac_code), .out_mode(out_mode)
  );

  // {load_n during frame, frame, expected dac_code}
  localparam logic [96:0] VEC [8] = '{
    {1'b1, 32'h0001_2340, 64'h0000_0000_0000_0000},  // R3 write A only
    {1'b1, 32'h0100_0000, 64'h0000_0000_0000_1234},  // R4 promote A
    {1'b1, 32'h0015_5550, 64'h0000_0000_0000_1234},  // R3 write B
    {1'b1, 32'h0027_7770, 64'h0000_0000_0000_1234},  // R2 address 0010 = C
    {1'b1, 32'h0239_9990, 64'h9999_7777_5555_1234},  // R5 write D, promote all
    {1'b1, 32'h03FA_BCD0, 64'hABCD_ABCD_ABCD_ABCD},  // R6 broadcast write+update
    {1'b0, 32'h0051_1110, 64'hABCD_ABCD_ABCD_ABCD},  // R2 address 0101 ignored
    {1'b0, 32'h0010_F0F0, 64'hABCD_ABCD_0F0F_ABCD}   // R8 load low, immediate
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] f, logic ln);
    @(negedge clk);
    frame_data = f; frame_valid = 1; load_n = ln;
    @(negedge clk);
    frame_valid = 0; load_n = 1;
  endtask

  task automatic set_clear(logic v);
    @(negedge clk); clear_n = v; @(negedge clk);
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 0; @(negedge clk); load_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset codes", dac_code, 64'h0);
    chk("R1 reset modes", {56'h0, out_mode}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", dac_code, 64'h0);

    foreach (VEC[k]) begin
      send(VEC[k][95:64], VEC[k][96]);
      chk($sformatf("vector %0d (R2..R8)", k), dac_code, VEC[k][63:0]);
    end

    // R7 override channel A
    send(32'h0600_0001, 1);
    send(32'h0002_2220, 1);
    chk("R7 overridden A immediate", dac_code, 64'hABCD_ABCD_0F0F_2222);
    send(32'h0013_3330, 1);
    chk("R7 B not overridden holds", dac_code, 64'hABCD_ABCD_0F0F_2222);
    pulse_load();
    chk("R8 load pulse promotes B", dac_code, 64'hABCD_ABCD_3333_2222);

    // R9 clear codes
    send(32'h0500_0001, 1);
    set_clear(0);
    chk("R9 clear select 01", dac_code, 64'h8000_8000_8000_8000);
    send(32'h0024_4440, 1);
    pulse_load();
    chk("R10 load ignored while clear low", dac_code, 64'h8000_8000_8000_8000);
    set_clear(1);
    send(32'h0500_0003, 1);
    set_clear(0);
    chk("R9 clear select 11 no-op", dac_code, 64'h8000_8000_8000_8000);
    set_clear(1);
    send(32'h0500_0002, 1);
    set_clear(0);
    chk("R9 clear select 10", dac_code, 64'hFFFF_FFFF_FFFF_FFFF);
    set_clear(1);
    pulse_load();
    chk("R9 clear also loads inputs", dac_code, 64'hFFFF_FFFF_FFFF_FFFF);

    // R11 power-down
    send(32'h0400_0205, 1);
    chk("R11 modes A,C = 10", {56'h0, out_mode}, 64'h22);
    chk("R11 codes kept", dac_code, 64'hFFFF_FFFF_FFFF_FFFF);
    // R12 power-up restore
    send(32'h0026_6660, 1);
    send(32'h0400_0004, 1);
    chk("R12 power-up load high keeps DAC", dac_code, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R12 mode C normal", {56'h0, out_mode}, 64'h02);
    send(32'h0400_0304, 1);
    chk("R11 mode C open", {56'h0, out_mode}, 64'h32);
    send(32'h0400_0004, 0);
    chk("R12 power-up load low takes input", dac_code, 64'hFFFF_6666_FFFF_FFFF);

    // R13 software reset beats clear edge and load
    por_mid = 1;
    @(negedge clk);
    frame_data = 32'h0700_0000; frame_valid = 1; clear_n = 0; load_n = 0;
    @(negedge clk);
    frame_valid = 0; load_n = 1;
    chk("R13 soft reset midscale", dac_code, 64'h8000_8000_8000_8000);
    chk("R13 soft reset modes", {56'h0, out_mode}, 64'h0);
    set_clear(1);
    send(32'h0001_1110, 1);
    chk("R13 override mask cleared", dac_code, 64'h8000_8000_8000_8000);
    set_clear(0);
    chk("R13 clear select back to 00", dac_code, 64'h0);
    set_clear(1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule